// File: doc/BRIEF.md
# Standard-Mode Printer Port Register Block

This block gives a host a standard-mode printer port through three byte-wide registers: a data register, a status register and a control register. The host bus is a plain single-cycle register interface. A write takes effect at the clock edge where `acc_en` and `acc_wr` are high. A read returns `acc_rdata` combinationally in the same cycle, and any side effect of the read lands at that clock edge.

The printer handshake is modelled inside the block. When a control write raises the strobe bit while select and init are both set, the port marks itself not busy. If strobe was low before that write, it hands the stored data byte to the printer side as a one-cycle `prn_valid` pulse. Each later status read steps the acknowledge and busy bits through the handshake. A control write that drops strobe can raise a level interrupt. The next status read clears that interrupt.

In the reverse direction, `rev_load` captures `rev_data` into an input latch. A data read returns that latch when the direction bit is set. The printer-side output has no back-pressure: the consumer must take every pulse in the cycle it is shown.

Top module: `lpt_port`

## Requirements
- R1: After reset, a data read returns 0xFF, a status read returns 0xD8, a control read returns 0x0C, and `irq` is low.
- R2: Only the low 3 bits of `acc_addr` select a register: offset 0 is data, offset 1 is status and offset 2 is control. For example, address 8 aliases data. Reads at offsets 3 to 7 return 0xFF.
- R3: A data read returns the reverse input latch when control bit 5 (direction) is 1. It returns the last byte written to offset 0 when that bit is 0. The input latch resets to 0xFF.
- R4: A control write with bit 2 (init) clear sets status to 0xD8 and emits nothing.
- R5: A control write with init (bit 2), select (bit 3) and strobe (bit 0) all set clears status bit 7 (busy) at that edge.
- R6: `prn_valid` pulses for exactly one cycle, with `prn_data` equal to the stored data byte, in the cycle after a control write that has init, select and strobe set while the previously stored strobe bit was 0. No other write emits a byte.
- R7: A control write with init and select set and strobe clear sets the interrupt flag only when the previously stored control had bit 4 (interrupt enable) set. `irq` is high from the cycle after that write.
- R8: Any status read returns the status value and brings `irq` low from the next cycle.
- R9: After a status read, if status busy (bit 7) is 0 and stored strobe is 0, then: when ack (bit 6) is 1 it is cleared; otherwise ack and busy are both set. Otherwise status is unchanged.
- R10: A control read returns the full byte last written to offset 2.
- R11: Writes to offset 1 and to offsets 3 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register address; low 3 bits used |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid in the access cycle |
| rev_load | input | 1 | Capture `rev_data` into the input latch |
| rev_data | input | 8 | Reverse-direction input byte |
| prn_valid | output | 1 | One-cycle pulse: byte sent to printer |
| prn_data | output | 8 | Byte sent to printer |
| irq | output | 1 | Level interrupt, equals pending flag |

## Verification
The embedded properties check several rules on every cycle:
- a control write with init clear restores the status;
- a strobe-with-select write clears busy;
- any status read drops `irq`;
- every `prn_valid` pulse lasts one cycle and traces back to a control write;
- the unused offsets read 0xFF.

Some behaviour depends on history, and only the bench's scenarios can show it:
- the ack/busy sequence across consecutive status reads;
- an interrupt that depends on the previously stored enable bit;
- the strobe-edge rule that suppresses a repeated emit;
- the direction-dependent data read.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 3;

  localparam logic [OFF_W-1:0] OFF_DATA = 3'd0;
  localparam logic [OFF_W-1:0] OFF_STAT = 3'd1;
  localparam logic [OFF_W-1:0] OFF_CTRL = 3'd2;

  // status bit positions
  localparam int ST_NBUSY = 7;
  localparam int ST_ACK   = 6;

  // control bit positions
  localparam int CT_DIR  = 5;
  localparam int CT_IEN  = 4;
  localparam int CT_SEL  = 3;
  localparam int CT_INIT = 2;
  localparam int CT_STB  = 0;

  localparam logic [BYTE_W-1:0] STAT_IDLE = 8'hD8;
  localparam logic [BYTE_W-1:0] CTRL_RST  = 8'h0C;
  localparam logic [BYTE_W-1:0] BYTE_ONES = 8'hFF;
endpackage

// File: rtl/lpt_decode.sv
module lpt_decode
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [OFF_W-1:0]  off,
  output logic              wr_data,
  output logic              wr_ctrl,
  output logic              rd_stat
);
  assign off     = OFF_W'(acc_addr);
  assign wr_data = acc_en &  acc_wr & (off == OFF_DATA);
  assign wr_ctrl = acc_en &  acc_wr & (off == OFF_CTRL);
  assign rd_stat = acc_en & ~acc_wr & (off == OFF_STAT);
endmodule

// File: rtl/lpt_handshake.sv
module lpt_handshake
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              rd_stat,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] status,
  output logic [BYTE_W-1:0] control,
  output logic              emit_req,
  output logic              irq
);
  logic [BYTE_W-1:0] stat_q, ctrl_q;
  logic              pend_q;
  logic              hs_active;

  // init and select both asserted in the incoming control byte
  assign hs_active = wdata[CT_INIT] & wdata[CT_SEL];
  // strobe rising edge judged against the stored (old) control
  assign emit_req  = wr_ctrl & hs_active & wdata[CT_STB] & ~ctrl_q[CT_STB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= STAT_IDLE;
      ctrl_q <= CTRL_RST;
      pend_q <= 1'b0;
    end else if (wr_ctrl) begin
      if (!wdata[CT_INIT]) begin
        stat_q <= STAT_IDLE;
      end else if (wdata[CT_SEL]) begin
        if (wdata[CT_STB])   stat_q[ST_NBUSY] <= 1'b0;
        else if (ctrl_q[CT_IEN]) pend_q <= 1'b1;
      end
      ctrl_q <= wdata;   // stored after side effects used the old value
    end else if (rd_stat) begin
      pend_q <= 1'b0;
      if (!stat_q[ST_NBUSY] && !ctrl_q[CT_STB]) begin
        if (stat_q[ST_ACK]) begin
          stat_q[ST_ACK] <= 1'b0;
        end else begin
          stat_q[ST_ACK]   <= 1'b1;
          stat_q[ST_NBUSY] <= 1'b1;
        end
      end
    end
  end

  assign status  = stat_q;
  assign control = ctrl_q;
  assign irq     = pend_q;

  p_init_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wdata[CT_INIT]) |=> (status == STAT_IDLE));

  p_busy_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && hs_active && wdata[CT_STB]) |=> !status[ST_NBUSY]);

  p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> !irq);

  p_irq_needs_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_ctrl));
endmodule

// File: rtl/lpt_datapath.sv
module lpt_datapath
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFF_W-1:0]  off,
  input  logic              wr_data,
  input  logic              wr_ctrl,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              emit_req,
  input  logic [BYTE_W-1:0] status,
  input  logic [BYTE_W-1:0] control,
  input  logic              rev_load,
  input  logic [BYTE_W-1:0] rev_data,
  output logic [BYTE_W-1:0] rdata,
  output logic              prn_valid,
  output logic [BYTE_W-1:0] prn_data
);
  logic [BYTE_W-1:0] out_q, in_q, prn_q;
  logic              vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= BYTE_ONES;
      in_q  <= BYTE_ONES;
      prn_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (wr_data)  out_q <= wdata;
      if (rev_load) in_q  <= rev_data;
      vld_q <= emit_req;
      if (emit_req) prn_q <= out_q;
    end
  end

  always_comb begin
    unique case (off)
      OFF_DATA: rdata = control[CT_DIR] ? in_q : out_q;
      OFF_STAT: rdata = status;
      OFF_CTRL: rdata = control;
      default:  rdata = BYTE_ONES;
    endcase
  end

  assign prn_valid = vld_q;
  assign prn_data  = prn_q;

  p_emit_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prn_valid |=> !prn_valid);

  p_emit_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prn_valid |-> $past(wr_ctrl));

  p_hole_reads_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (off > OFF_CTRL) |-> (rdata == BYTE_ONES));
endmodule

// File: rtl/lpt_port.sv
module lpt_port
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        acc_rdata,
  input  logic              rev_load,
  input  logic [7:0]        rev_data,
  output logic              prn_valid,
  output logic [7:0]        prn_data,
  output logic              irq
);
  logic [OFF_W-1:0]  off;
  logic              wr_data, wr_ctrl, rd_stat, emit_req;
  logic [BYTE_W-1:0] status, control;

  lpt_decode #(.ADDR_W(ADDR_W)) u_dec (
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .off(off), .wr_data(wr_data), .wr_ctrl(wr_ctrl), .rd_stat(rd_stat)
  );

  lpt_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .rd_stat(rd_stat),
    .wdata(acc_wdata), .status(status), .control(control),
    .emit_req(emit_req), .irq(irq)
  );

  lpt_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .off(off), .wr_data(wr_data),
    .wr_ctrl(wr_ctrl), .wdata(acc_wdata), .emit_req(emit_req),
    .status(status), .control(control), .rev_load(rev_load),
    .rev_data(rev_data), .rdata(acc_rdata), .prn_valid(prn_valid),
    .prn_data(prn_data)
  );
endmodule

// File: tb/test_lpt_port.sv
module test_lpt_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_en = 1'b0, acc_wr = 1'b0;
  logic [7:0] acc_addr = '0, acc_wdata = '0, acc_rdata;
  logic       rev_load = 1'b0;
  logic [7:0] rev_data = '0;
  logic       prn_valid, irq;
  logic [7:0] prn_data;
  int         n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  lpt_port i_lpt_port (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .rev_load(rev_load), .rev_data(rev_data), .prn_valid(prn_valid),
    .prn_data(prn_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one access: read data sampled before the edge, registered outputs after it
  task automatic access(input logic wr, input logic [7:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output logic ir, output logic vl,
                        output logic [7:0] od);
    acc_en = 1'b1; acc_wr = wr; acc_addr = a; acc_wdata = d;
    #1 rd = acc_rdata;
    @(posedge clk); @(negedge clk);
    ir = irq; vl = prn_valid; od = prn_data;
    acc_en = 1'b0;
  endtask

  // fields: wr, addr[3:0], wdata, exp_rd, exp_irq, exp_vld, exp_od
  localparam int NV = 22;
  localparam logic [30:0] VEC [0:NV-1] = '{
    {1'b0,4'h0,8'h00,8'hFF,1'b0,1'b0,8'h00}, // R1 data
    {1'b0,4'h1,8'h00,8'hD8,1'b0,1'b0,8'h00}, // R1 status
    {1'b0,4'h2,8'h00,8'h0C,1'b0,1'b0,8'h00}, // R1 control
    {1'b0,4'h5,8'h00,8'hFF,1'b0,1'b0,8'h00}, // R2 hole
    {1'b1,4'h0,8'h5A,8'h00,1'b0,1'b0,8'h00}, // write data
    {1'b0,4'h0,8'h00,8'h5A,1'b0,1'b0,8'h00}, // R3 dir=0
    {1'b0,4'h8,8'h00,8'h5A,1'b0,1'b0,8'h00}, // R2 alias
    {1'b1,4'h2,8'h0D,8'h00,1'b0,1'b1,8'h5A}, // R5 R6 emit
    {1'b0,4'h1,8'h00,8'h58,1'b0,1'b0,8'h00}, // R5 busy clear
    {1'b1,4'h2,8'h0D,8'h00,1'b0,1'b0,8'h00}, // R6 no re-emit
    {1'b1,4'h0,8'h33,8'h00,1'b0,1'b0,8'h00},
    {1'b1,4'h2,8'h0C,8'h00,1'b0,1'b0,8'h00}, // R7 ien was 0
    {1'b0,4'h1,8'h00,8'h58,1'b0,1'b0,8'h00}, // R9 ack->0
    {1'b0,4'h1,8'h00,8'h18,1'b0,1'b0,8'h00}, // R9 ack,busy->1
    {1'b0,4'h1,8'h00,8'hD8,1'b0,1'b0,8'h00}, // R9 stable
    {1'b1,4'h2,8'h1C,8'h00,1'b0,1'b0,8'h00}, // R7 old ien 0
    {1'b1,4'h2,8'h1C,8'h00,1'b1,1'b0,8'h00}, // R7 irq set
    {1'b0,4'h2,8'h00,8'h1C,1'b1,1'b0,8'h00}, // R10
    {1'b1,4'h1,8'h00,8'h00,1'b1,1'b0,8'h00}, // R11 status write
    {1'b0,4'h1,8'h00,8'hD8,1'b0,1'b0,8'h00}, // R8 R11
    {1'b1,4'h2,8'h24,8'h00,1'b0,1'b0,8'h00}, // dir=1, sel=0
    {1'b0,4'h0,8'h00,8'hFF,1'b0,1'b0,8'h00}  // R3 latch reset
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] rd, od;
    logic       ir, vl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 irq", {7'd0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][30], {4'h0, VEC[i][29:26]}, VEC[i][25:18], rd, ir, vl, od);
      if (!VEC[i][30]) chk($sformatf("vec%0d rdata", i), rd, VEC[i][17:10]);
      chk($sformatf("vec%0d irq", i), {7'd0, ir}, {7'd0, VEC[i][9]});
      chk($sformatf("vec%0d valid", i), {7'd0, vl}, {7'd0, VEC[i][8]});
      if (VEC[i][8]) chk($sformatf("vec%0d R6 byte", i), od, VEC[i][7:0]);
    end

    // R3: reverse latch when direction set
    rev_data = 8'hA5; rev_load = 1'b1;
    @(posedge clk); @(negedge clk); rev_load = 1'b0;
    access(1'b0, 8'h00, 8'h00, rd, ir, vl, od); chk("R3 latch", rd, 8'hA5);
    access(1'b1, 8'h02, 8'h0C, rd, ir, vl, od);
    access(1'b0, 8'h00, 8'h00, rd, ir, vl, od); chk("R3 written", rd, 8'h33);
    // R6 emit of 0x33, R5 busy
    access(1'b1, 8'h02, 8'h0D, rd, ir, vl, od);
    chk("R6 valid", {7'd0, vl}, 8'h01); chk("R6 byte", od, 8'h33);
    access(1'b0, 8'h02, 8'h00, rd, ir, vl, od); chk("R6 one cycle", {7'd0, prn_valid}, 8'h00);
    // R4: init clear restores status, no emit
    access(1'b1, 8'h02, 8'h09, rd, ir, vl, od); chk("R4 no emit", {7'd0, vl}, 8'h00);
    access(1'b0, 8'h01, 8'h00, rd, ir, vl, od); chk("R4 status", rd, 8'hD8);
    // R6: select clear, strobe rises -> no emit
    access(1'b1, 8'h02, 8'h04, rd, ir, vl, od);
    access(1'b1, 8'h02, 8'h05, rd, ir, vl, od); chk("R6 sel clear", {7'd0, vl}, 8'h00);
    // R11: writes to holes ignored
    access(1'b1, 8'h06, 8'h00, rd, ir, vl, od);
    access(1'b1, 8'h03, 8'h20, rd, ir, vl, od);
    access(1'b0, 8'h02, 8'h00, rd, ir, vl, od); chk("R11 ctrl", rd, 8'h05);
    access(1'b0, 8'h00, 8'h00, rd, ir, vl, od); chk("R11 data", rd, 8'h33);
    // R1: reset in mid-run
    access(1'b1, 8'h00, 8'h77, rd, ir, vl, od);
    access(1'b1, 8'h02, 8'h1C, rd, ir, vl, od);
    access(1'b1, 8'h02, 8'h1C, rd, ir, vl, od); chk("R7 irq again", {7'd0, ir}, 8'h01);
    rst_n = 1'b0; @(posedge clk); @(negedge clk); rst_n = 1'b1;
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    access(1'b0, 8'h00, 8'h00, rd, ir, vl, od); chk("R1 data after reset", rd, 8'hFF);
    access(1'b0, 8'h02, 8'h00, rd, ir, vl, od); chk("R1 ctrl after reset", rd, 8'h0C);
    access(1'b0, 8'h01, 8'h00, rd, ir, vl, od); chk("R1 status after reset", rd, 8'hD8);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule